// File: doc/BRIEF.md
# Dual-Rail Wavefront Input Controller

This block takes a single-rail plaintext word and a single-rail key word and presents them to downstream dual-rail logic as a stream of alternating wavefronts. A DATA wavefront carries each logical bit on a pair of complementary rails. A NULL wavefront drives every rail low. The consumer paces the stream through its completion acknowledge. A high acknowledge asks for NULL. A low acknowledge asks for the next DATA wavefront.

The model is cycle-based. Every wavefront event is sampled on a free-running clock, and both outputs come from registers. Single-rail inputs are captured only at the edge where a NULL phase gives way to DATA. Once a DATA wavefront is on the wires, it stays there unchanged until the consumer requests NULL. Every DATA word has the same number of asserted rails whatever its value. Each DATA-to-NULL or NULL-to-DATA change therefore toggles the same number of wires.

Top module: `dr_wave_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until a DATA wavefront is issued, both dual-rail outputs are all zero (NULL).
- R2: In a DATA wavefront, logical bit i is carried on rails [2i+1:2i]. The value 2'b10 means logic 1 and 2'b01 means logic 0.
- R3: No rail pair of either output is ever 2'b11.
- R4: If ack_i is sampled high at a clock edge, both outputs are all zero after that edge.
- R5: If ack_i is sampled low while NULL is being driven, both outputs carry the encoding of plain_i and key_i as sampled at that same edge, starting right after it.
- R6: While DATA is being driven and ack_i stays low, both outputs hold their value, even if plain_i and key_i change.
- R7: Every byte of a DATA wavefront (16 rails) has exactly 8 rails high, so a 256-rail DATA word has exactly 128 rails high.
- R8: Each change of an output from NULL to DATA, or from DATA to NULL, toggles exactly 128 of its 256 wires.
- R9: After reset, the first DATA wavefront appears only at the first edge where ack_i is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for wavefront events |
| rst_n | input | 1 | Active-low reset; forces NULL |
| ack_i | input | 1 | Consumer acknowledge: 1 requests NULL, 0 requests DATA |
| plain_i | input | 128 | Single-rail plaintext |
| key_i | input | 128 | Single-rail key |
| plain_dr_o | output | 256 | Dual-rail plaintext wavefront |
| key_dr_o | output | 256 | Dual-rail key wavefront |

## Verification
Every result is due one clock after the edge that samples ack_i and the single-rail words. Both outputs come from a single register stage, so a NULL request, a DATA capture and a hold all appear right after that edge. The driver changes the inputs on the falling edge and queues the value that the next rising edge must produce. The monitor takes that item off the queue 1 ns after the rising edge and compares it with both outputs. At the same point it checks the per-byte rail counts and, whenever the phase has changed, the number of wires that toggled since the previous sample.

// File: rtl/dr_wave_pkg.sv
package dr_wave_pkg;

    typedef enum logic {
        PH_NULL = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    localparam logic [1:0] RAIL_ONE  = 2'b10;
    localparam logic [1:0] RAIL_ZERO = 2'b01;

    function automatic logic [1:0] encode_bit(input logic b);
        return b ? RAIL_ONE : RAIL_ZERO;
    endfunction

endpackage

// File: rtl/dr_encoder.sv
module dr_encoder #(
    parameter int BITS = 128,
    localparam int RAILS = 2 * BITS
) (
    input  logic [BITS-1:0]  bits_i,
    output logic [RAILS-1:0] rails_o
);
    import dr_wave_pkg::*;

    for (genvar i = 0; i < BITS; i++) begin : g_bit
        assign rails_o[2*i +: 2] = encode_bit(bits_i[i]);
    end

endmodule

// File: rtl/dr_wave_seq.sv
module dr_wave_seq
    import dr_wave_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ack_i,
    output logic   load_o,
    output logic   clear_o,
    output phase_e phase_o
);

    typedef struct packed {
        phase_e phase;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        load_o  = 1'b0;
        clear_o = 1'b0;
        if (ack_i) begin
            clear_o     = 1'b1;
            st_d.phase  = PH_NULL;
        end else if (st_q.phase == PH_NULL) begin
            load_o      = 1'b1;
            st_d.phase  = PH_DATA;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_NULL};
        else        st_q <= st_d;
    end

    assign phase_o = st_q.phase;

    // R6
    data_hold_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DATA && !ack_i) |=> (phase_o == PH_DATA));

endmodule

// File: rtl/dr_rail_reg.sv
module dr_rail_reg #(
    parameter int RAILS = 256,
    localparam int PAIRS = RAILS / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             clear_i,
    input  logic [RAILS-1:0] d_i,
    output logic [RAILS-1:0] q_o
);

    logic [RAILS-1:0] rail_d, rail_q;
    logic             bad_pair;

    always_comb begin
        rail_d = rail_q;
        if (clear_i)     rail_d = '0;
        else if (load_i) rail_d = d_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rail_q <= '0;
        else        rail_q <= rail_d;
    end

    assign q_o = rail_q;

    always_comb begin
        bad_pair = 1'b0;
        for (int p = 0; p < PAIRS; p++) begin
            if (rail_q[2*p +: 2] == 2'b11) bad_pair = 1'b1;
        end
    end

    // R3
    no_both_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_pair);

    // R7
    const_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_q != '0) |-> ($countones(rail_q) == PAIRS));

endmodule

// File: rtl/dr_wave_ctrl.sv
module dr_wave_ctrl
    import dr_wave_pkg::*;
#(
    parameter int BITS = 128,
    localparam int RAILS = 2 * BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_i,
    input  logic [BITS-1:0]  plain_i,
    input  logic [BITS-1:0]  key_i,
    output logic [RAILS-1:0] plain_dr_o,
    output logic [RAILS-1:0] key_dr_o
);

    logic             load, clear;
    phase_e           phase;
    logic [RAILS-1:0] plain_enc, key_enc;

    dr_wave_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_i   (ack_i),
        .load_o  (load),
        .clear_o (clear),
        .phase_o (phase)
    );

    dr_encoder #(.BITS(BITS)) u_enc_plain (
        .bits_i  (plain_i),
        .rails_o (plain_enc)
    );

    dr_encoder #(.BITS(BITS)) u_enc_key (
        .bits_i  (key_i),
        .rails_o (key_enc)
    );

    dr_rail_reg #(.RAILS(RAILS)) u_reg_plain (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .clear_i (clear),
        .d_i     (plain_enc),
        .q_o     (plain_dr_o)
    );

    dr_rail_reg #(.RAILS(RAILS)) u_reg_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .clear_i (clear),
        .d_i     (key_enc),
        .q_o     (key_dr_o)
    );

    // R4
    ack_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> (plain_dr_o == '0 && key_dr_o == '0));

    // R6
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && !ack_i) |=> ($stable(plain_dr_o) && $stable(key_dr_o)));

    // R8
    toggle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((plain_dr_o == '0) != ($past(plain_dr_o) == '0))
        |-> ($countones(plain_dr_o ^ $past(plain_dr_o)) == BITS));

    // R9
    null_until_ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_NULL && ack_i) |=> (phase == PH_NULL));

endmodule

// File: tb/tb_dr_wave_ctrl.sv
module tb_dr_wave_ctrl;

    localparam int BITS  = 128;
    localparam int RAILS = 2 * BITS;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ack_i = 1'b1;
    logic [BITS-1:0]  plain_i = '0;
    logic [BITS-1:0]  key_i = '0;
    logic [RAILS-1:0] plain_dr_o, key_dr_o;

    always #2.5 clk = ~clk;

    dr_wave_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_i      (ack_i),
        .plain_i    (plain_i),
        .key_i      (key_i),
        .plain_dr_o (plain_dr_o),
        .key_dr_o   (key_dr_o)
    );

    typedef struct {
        logic [RAILS-1:0] p;
        logic [RAILS-1:0] k;
        bit               data;
        string            tag;
    } exp_t;

    exp_t expq[$];
    int   checks = 0;
    int   errors = 0;
    bit   exp_data = 1'b0;
    logic [RAILS-1:0] exp_p = '0, exp_k = '0;
    bit   done = 1'b0;

    function automatic logic [RAILS-1:0] enc(input logic [BITS-1:0] w);
        logic [RAILS-1:0] r;
        for (int i = 0; i < BITS; i++) r[2*i +: 2] = w[i] ? 2'b10 : 2'b01;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [RAILS-1:0] act,
                         input logic [RAILS-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step(input bit ack, input logic [BITS-1:0] p, input logic [BITS-1:0] k,
                        input string tag);
        exp_t it;
        @(negedge clk);
        ack_i   = ack;
        plain_i = p;
        key_i   = k;
        if (ack) begin
            exp_data = 1'b0; exp_p = '0; exp_k = '0;
        end else if (!exp_data) begin
            exp_data = 1'b1; exp_p = enc(p); exp_k = enc(k);
        end
        it.p = exp_p; it.k = exp_k; it.data = exp_data; it.tag = tag;
        expq.push_back(it);
    endtask

    logic [RAILS-1:0] prev_p = '0, prev_k = '0;
    bit               prev_data = 1'b0;

    always @(posedge clk) begin
        #1;
        if (expq.size() > 0) begin
            exp_t it;
            it = expq.pop_front();
            check(plain_dr_o == it.p, {it.tag, " plain"}, plain_dr_o, it.p);
            check(key_dr_o == it.k, {it.tag, " key"}, key_dr_o, it.k);
            begin
                bit bad = 1'b0;
                for (int i = 0; i < BITS; i++)
                    if (plain_dr_o[2*i +: 2] == 2'b11 || key_dr_o[2*i +: 2] == 2'b11) bad = 1'b1;
                check(!bad, "R3 no illegal pair", plain_dr_o, key_dr_o);
            end
            if (it.data) begin
                bit badw = 1'b0;
                for (int b = 0; b < RAILS / 16; b++)
                    if ($countones(plain_dr_o[16*b +: 16]) != 8 ||
                        $countones(key_dr_o[16*b +: 16]) != 8) badw = 1'b1;
                check(!badw, "R7 byte weight", plain_dr_o, key_dr_o);
            end
            if (it.data != prev_data) begin
                check($countones(plain_dr_o ^ prev_p) == BITS && $countones(key_dr_o ^ prev_k) == BITS,
                      "R8 toggle count", plain_dr_o ^ prev_p, key_dr_o ^ prev_k);
            end
            prev_p = plain_dr_o; prev_k = key_dr_o; prev_data = it.data;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(plain_dr_o == '0 && key_dr_o == '0, "R1 NULL in reset", plain_dr_o, '0);
        rst_n = 1'b1;
        step(1'b1, 128'hdead, 128'hbeef, "R1 NULL after reset");
        step(1'b1, 128'h1234, 128'h5678, "R9 stays NULL while ack high");
        step(1'b0, 128'h1, 128'h2, "R5 R9 first DATA; R2 bit0=1 key bit1=1");
        step(1'b0, 128'hffff, 128'haaaa, "R6 hold while inputs change");
        step(1'b0, '1, '0, "R6 hold again");
        step(1'b1, '1, '1, "R4 NULL on ack");
        step(1'b0, '1, '0, "R2 R5 all ones / all zeros");
        step(1'b1, '0, '0, "R4 NULL");
        step(1'b0, {64{2'b10}}, {64{2'b01}}, "R2 R5 alternating");
        step(1'b1, '0, '0, "R4 NULL");
        step(1'b1, '0, '0, "R4 NULL held");
        for (int n = 0; n < 40; n++) begin
            logic [BITS-1:0] rp, rk;
            rp = {$urandom, $urandom, $urandom, $urandom};
            rk = {$urandom, $urandom, $urandom, $urandom};
            step(($urandom % 3) == 0, rp, rk, "R5 R6 R4 random");
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule